// File: doc/BRIEF.md
# Direction-Aware Word Collection Buffer

This block collects a message of 32-bit words from a bus, one word per write strobe, into a row of word slots. The slots are laid out so that a downstream cipher core can copy slot i straight into its working register i with no extra wiring. The message length can be set from two to eight words. The order of the words in the slots depends on the cipher direction. When encrypting, the words fill the slots from slot 0 upward. When decrypting, every new word enters slot 0 and the older words move up by one place, so the message ends up reversed.

A flag reports that the message is complete. The consumer then gives a one-cycle transfer pulse, which empties the buffer so the next message can start at once. A second path takes the parallel result from the core and sends it out on a 32-bit port one word per shift request. A valid flag marks each word, and exactly as many words leave as the message had.

Top module: `msg_reorder_buf`

## Requirements
- R1: After reset the completion flag `msg_full` and the output flag `out_valid` are both 0, and the buffer holds no words.
- R2: When `cfg_decrypt` = 0, the k-th accepted word after the buffer empties (k = 0, 1, ...) is stored in slot k, which is bits [32k+31:32k] of `slot_q`.
- R3: When `cfg_decrypt` = 1, each accepted word is stored in slot 0 and every slot i moves to slot i+1. After n words w0..w(n-1), slot i holds w(n-1-i).
- R4: `msg_full` rises on the clock edge that accepts the n-th word. It is 0 before that edge and stays 1 until a transfer. The count of stored words never exceeds n.
- R5: A write that arrives while `msg_full` is 1 is dropped and leaves every slot unchanged.
- R6: A `xfer` pulse empties the buffer, so `msg_full` is 0 from the next cycle on. A write in the same cycle as `xfer` is dropped. The next accepted write is taken as word 0 of a new message.
- R7: `cfg_words` and `cfg_decrypt` are sampled only while the buffer is empty, including the cycle of the first write. A change while words are held has no effect on that message.
- R8: A `cfg_words` value below 2 is treated as 2, and a value above 8 is treated as 8.
- R9: `res_load` loads the eight result words from `res_data`. `out_data` then shows word 0 with `out_valid` = 1, and each `res_shift` moves to the next word. After n shifts, where n is the word count in force at the last transfer, `out_valid` falls. A shift while `out_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_words | input | 4 | Message length in words (2 to 8) |
| cfg_decrypt | input | 1 | 1 = decryption ordering, 0 = encryption ordering |
| in_data | input | 32 | Input word |
| in_wr | input | 1 | Write strobe for `in_data` |
| xfer | input | 1 | Transfer pulse; empties the buffer |
| slot_q | output | 256 | All slots in parallel, slot i at bits [32i+31:32i] |
| msg_full | output | 1 | Message complete |
| res_load | input | 1 | Load the result words from `res_data` |
| res_data | input | 256 | Result words, word i at bits [32i+31:32i] |
| res_shift | input | 1 | Advance to the next output word |
| out_data | output | 32 | Current output word |
| out_valid | output | 1 | `out_data` holds a valid result word |

## Verification
The bench fills the buffer with distinct word values in both directions, using a short message of three words and a full message of eight. Encryption ordering then shows up as ascending slots and decryption ordering as a mirrored row, and any off-by-one slot is exposed. Further cases test the edges of the input handling:
- extra writes made after the message is complete;
- a write in the same cycle as a transfer;
- a configuration change in the middle of a message;
- word counts outside the 2 to 8 range.

The output path is loaded with eight distinct words while only three are valid. This separates a correct stop after n words from a path that runs on to the full width.

// File: rtl/msg_reorder_buf.sv
module msg_reorder_buf #(
  parameter int W    = 32,
  parameter int N    = 8,
  parameter int MINW = 2,
  localparam int CW  = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cfg_words,
  input  logic           cfg_decrypt,
  input  logic [W-1:0]   in_data,
  input  logic           in_wr,
  input  logic           xfer,
  output logic [N*W-1:0] slot_q,
  output logic           msg_full,
  input  logic           res_load,
  input  logic [N*W-1:0] res_data,
  input  logic           res_shift,
  output logic [W-1:0]   out_data,
  output logic           out_valid
);

  logic [W-1:0]  slot [N];
  logic [W-1:0]  sh   [N];
  logic [CW-1:0] cnt, act_words, run_words, out_left;
  logic          act_dec;

  logic [CW-1:0] cfg_cl, eff_words;
  logic          eff_dec, wr_ok;

  assign cfg_cl    = (cfg_words < CW'(MINW)) ? CW'(MINW) :
                     (cfg_words > CW'(N))    ? CW'(N) : cfg_words;
  assign eff_words = (cnt == '0) ? cfg_cl : act_words;
  assign eff_dec   = (cnt == '0) ? cfg_decrypt : act_dec;
  assign wr_ok     = in_wr && !xfer && (cnt < eff_words);
  assign msg_full  = (cnt == act_words);
  assign out_data  = sh[0];
  assign out_valid = (out_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_words <= CW'(MINW);
      act_dec   <= 1'b0;
      run_words <= CW'(MINW);
    end else begin
      act_words <= eff_words;
      act_dec   <= eff_dec;
      if (xfer) begin
        cnt       <= '0;
        run_words <= act_words;
      end else if (wr_ok) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign slot_q[i*W +: W] = slot[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (wr_ok) begin
        if (eff_dec) begin
          if (i == 0) slot[i] <= in_data;
          else        slot[i] <= slot[(i > 0) ? i-1 : 0];
        end else if (cnt == CW'(i)) begin
          slot[i] <= in_data;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh[i] <= '0;
      else if (res_load)
        sh[i] <= res_data[i*W +: W];
      else if (res_shift && out_valid)
        sh[i] <= (i == N-1) ? '0 : sh[(i < N-1) ? i+1 : i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_left <= '0;
    else if (res_load)
      out_left <= run_words;
    else if (res_shift && out_valid)
      out_left <= out_left - 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_words); // R4
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_full && !xfer |=> msg_full); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    msg_full && !xfer |=> $stable(slot_q)); // R5
  AST_XFER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !msg_full); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && !xfer |=> $stable(act_words) && $stable(act_dec)); // R7
  AST_OUT_END: assert property (@(posedge clk) disable iff (!rst_n)
    res_shift && !res_load && out_left == CW'(1) |=> !out_valid); // R9
  AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !res_load |=> !out_valid && $stable(out_data)); // R9

endmodule

// File: tb/msg_reorder_buf_tb.sv
`timescale 1ns/1ps
module msg_reorder_buf_tb_top;
  logic         clk = 0, rst_n = 0;
  logic [3:0]   cfg_words = 4'd3;
  logic         cfg_decrypt = 0;
  logic [31:0]  in_data = '0;
  logic         in_wr = 0, xfer = 0;
  logic [255:0] slot_q;
  logic         msg_full;
  logic         res_load = 0, res_shift = 0;
  logic [255:0] res_data = '0;
  logic [31:0]  out_data;
  logic         out_valid;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  msg_reorder_buf dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_words(cfg_words), .cfg_decrypt(cfg_decrypt),
    .in_data(in_data), .in_wr(in_wr), .xfer(xfer), .slot_q(slot_q),
    .msg_full(msg_full), .res_load(res_load), .res_data(res_data),
    .res_shift(res_shift), .out_data(out_data), .out_valid(out_valid));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(int i);
    return slot_q[i*32 +: 32];
  endfunction

  task automatic wr(logic [31:0] d);
    in_data = d; in_wr = 1;
    @(posedge clk); #1 in_wr = 0;
  endtask

  task automatic pulse_xfer();
    xfer = 1;
    @(posedge clk); #1 xfer = 0;
  endtask

  task automatic load_result(int n);
    for (int i = 0; i < 8; i++) res_data[i*32 +: 32] = 32'hD000_0000 + i;
    for (int i = 0; i < n; i++) exp_q.push_back(32'hD000_0000 + i);
    res_load = 1;
    @(posedge clk); #1 res_load = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_shift && out_valid) begin
      if (exp_q.size() == 0) check("R9 extra word", out_data, 32'hxxxx_xxxx);
      else check("R9 output word", out_data, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    check("R1 full after reset", {31'b0, msg_full}, 0);
    check("R1 valid after reset", {31'b0, out_valid}, 0);

    // R2 encrypt, 3 words
    cfg_words = 3; cfg_decrypt = 0;
    wr(32'hA0); wr(32'hA1);
    check("R4 not full early", {31'b0, msg_full}, 0);
    wr(32'hA2);
    check("R4 full at n", {31'b0, msg_full}, 1);
    for (int i = 0; i < 3; i++) check("R2 enc slot", slot(i), 32'hA0 + i);
    wr(32'hEE);
    for (int i = 0; i < 3; i++) check("R5 dropped write", slot(i), 32'hA0 + i);
    check("R4 full holds", {31'b0, msg_full}, 1);

    // R6 transfer with simultaneous write
    in_data = 32'hBAD; in_wr = 1; xfer = 1;
    @(posedge clk); #1 in_wr = 0; xfer = 0;
    check("R6 empty after xfer", {31'b0, msg_full}, 0);
    wr(32'hB0); wr(32'hB1); wr(32'hB2);
    check("R6 write with xfer dropped", slot(0), 32'hB0);
    check("R6 back to back full", {31'b0, msg_full}, 1);

    // R9 output path, n = 3 captured at this transfer
    pulse_xfer();
    load_result(3);
    check("R9 valid after load", {31'b0, out_valid}, 1);
    res_shift = 1;
    repeat (5) @(posedge clk);
    #1 res_shift = 0;
    check("R9 valid falls", {31'b0, out_valid}, 0);
    check("R9 all words seen", exp_q.size(), 0);

    // R3 decrypt, 8 words
    cfg_words = 8; cfg_decrypt = 1;
    for (int k = 0; k < 8; k++) begin
      wr(32'hC0 + k);
      if (k == 6) check("R4 not full at 7", {31'b0, msg_full}, 0);
    end
    check("R4 full at 8", {31'b0, msg_full}, 1);
    for (int i = 0; i < 8; i++) check("R3 dec slot", slot(i), 32'hC7 - i);

    // R7 config change mid-message
    pulse_xfer();
    cfg_words = 2; cfg_decrypt = 0;
    wr(32'hE0);
    cfg_words = 5; cfg_decrypt = 1;
    wr(32'hE1);
    check("R7 count frozen", {31'b0, msg_full}, 1);
    check("R7 mode frozen s0", slot(0), 32'hE0);
    check("R7 mode frozen s1", slot(1), 32'hE1);

    // R8 clamping
    pulse_xfer();
    cfg_words = 1; cfg_decrypt = 0;
    wr(32'hF0);
    check("R8 low clamp not full", {31'b0, msg_full}, 0);
    wr(32'hF1);
    check("R8 low clamp full", {31'b0, msg_full}, 1);
    pulse_xfer();
    cfg_words = 12;
    for (int k = 0; k < 7; k++) wr(32'h100 + k);
    check("R8 high clamp not full", {31'b0, msg_full}, 0);
    wr(32'h107);
    check("R8 high clamp full", {31'b0, msg_full}, 1);
    check("R8 last slot", slot(7), 32'h107);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule